// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives stereo serial audio as a slave. A bit clock, a frame clock that selects the channel, and a data line arrive from an external source. The block samples all three in its own system clock domain. A static format pin chooses between two framings. In left-justified framing the first data bit sits on the first bit-clock rising edge of a slot. In I2S framing it sits one edge later. Apart from that one-edge delay, both formats run through a single framing engine.

Each word is 24 bits of two's complement and arrives MSB first. When the right-channel word of a pair is closed, the block presents the left and right words together and pulses a one-cycle strobe. A word that is cut short by an early frame-clock change has its missing low bits filled with zeros. Bits that arrive after the 24th are dropped.

An activity monitor watches the bit clock. When the bit clock stops, the monitor raises a loss flag. While the flag is up, both output words are forced to zero and framing restarts, so downstream logic receives silence.

Top module: `serial_audio_rx`

## Requirements
- R1: The frame clock and the data line are taken only at rising edges of the bit clock. A data value that changes while the bit clock is high has no effect on the captured word.
- R2: When `fmt_lj` is 1 (left-justified), the MSB is the data bit at the first rising bit-clock edge where the new frame-clock level is seen.
- R3: When `fmt_lj` is 0 (I2S), the MSB is the data bit at the second rising edge after the frame-clock change. The bit at the first edge is discarded.
- R4: A word holds 24 bits. They are received MSB first and placed in descending bit order, so the 24th bit received becomes bit 0.
- R5: Bits that arrive after the 24th bit of a slot and before the next frame-clock change leave the captured word unchanged.
- R6: The format pin is encoded as 1 = left-justified and 0 = I2S. The format may only be changed while the bit clock is stopped.
- R7: A frame-clock high slot is the left channel in left-justified mode. A frame-clock low slot is the left channel in I2S mode.
- R8: If the frame clock changes before 24 bits of a slot have arrived, the bits not received are zero in the output word.
- R9: A slot is closed at the next frame-clock change. When a right-channel slot is closed after a left slot, `left_out` and `right_out` are loaded with that pair. In the same cycle `pair_stb` is high for exactly one system-clock cycle. Both outputs then hold until the next pair.
- R10: `bclk_lost` rises after 64 consecutive system-clock cycles with no bit-clock edge. It clears in the cycle after any bit-clock edge is seen. It is 1 after reset.
- R11: While `bclk_lost` is high, `left_out` and `right_out` are zero and `pair_stb` stays low. After the clock returns, no pair is issued until a full left slot and a full right slot have been seen.
- R12: After reset, `pair_stb` is 0 and both output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_lj | input | 1 | Format select: 1 left-justified, 0 I2S |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame (left/right) clock |
| sdat_in | input | 1 | Serial data |
| left_out | output | 24 | Left sample of the last pair |
| right_out | output | 24 | Right sample of the last pair |
| pair_stb | output | 1 | One-cycle strobe when a new pair is loaded |
| bclk_lost | output | 1 | Bit clock has stopped; outputs muted |

## Verification
The hardest states to reach are the ones around a stopped bit clock. The bench must halt the bit clock in the middle of a stream and hold it long enough to cross the 64-cycle threshold. It then checks that the flag is still low partway through the quiet time, and that the flag and the muted outputs are present once the threshold has passed. The format is switched while the clock is stopped. Streaming then resumes with a preamble slot, which shows that framing restarts cleanly. Short words and overlong slots are mixed into the same streams so that zero-fill and bit-discard are both exercised on real pairs.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W      = 24,
  parameter int LOSS_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_lj,
  input  logic              bclk_in,
  input  logic              fclk_in,
  input  logic              sdat_in,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              pair_stb,
  output logic              bclk_lost
);

  localparam int GAP_W = $clog2(LOSS_CYCLES + 1);
  localparam int POS_W = $clog2(WORD_W + 2);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(LOSS_CYCLES);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOSS_CYCLES - 1);
  localparam logic [POS_W-1:0] POS_MAX  = '1;
  localparam logic [POS_W-1:0] TOP_BIT  = POS_W'(WORD_W - 1);

  logic [2:0] bck_q;
  logic [1:0] fck_q, dat_q, mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bck_q  <= '0;
      fck_q  <= '0;
      dat_q  <= '0;
      mode_q <= '0;
    end else begin
      bck_q  <= {bck_q[1:0], bclk_in};
      fck_q  <= {fck_q[0], fclk_in};
      dat_q  <= {dat_q[0], sdat_in};
      mode_q <= {mode_q[0], fmt_lj};
    end

  wire rise   = bck_q[1] & ~bck_q[2];
  wire toggle = bck_q[1] ^ bck_q[2];
  wire fs_bit = fck_q[1];
  wire d_bit  = dat_q[1];
  wire lj     = mode_q[1];

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap       <= GAP_MAX;
      bclk_lost <= 1'b1;
    end else if (toggle) begin
      gap       <= '0;
      bclk_lost <= 1'b0;
    end else begin
      if (gap != GAP_MAX) gap <= gap + 1'b1;
      if (gap == GAP_LAST) bclk_lost <= 1'b1;
    end

  logic              fs_prev, started, have_left;
  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] cur, hold;

  wire [POS_W-1:0] idx      = lj ? pos : pos - 1'b1;
  wire [POS_W-1:0] bitsel   = TOP_BIT - idx;
  wire             was_left = lj ? fs_prev : ~fs_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_prev   <= 1'b0;
      started   <= 1'b0;
      have_left <= 1'b0;
      pos       <= '0;
      cur       <= '0;
      hold      <= '0;
      left_out  <= '0;
      right_out <= '0;
      pair_stb  <= 1'b0;
    end else begin
      pair_stb <= 1'b0;
      if (bclk_lost) begin
        started   <= 1'b0;
        have_left <= 1'b0;
        left_out  <= '0;
        right_out <= '0;
      end else if (rise) begin
        fs_prev <= fs_bit;
        if (fs_bit != fs_prev) begin
          if (started) begin
            if (was_left) begin
              hold      <= cur;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_out  <= hold;
              right_out <= cur;
              pair_stb  <= 1'b1;
              have_left <= 1'b0;
            end
          end
          started <= 1'b1;
          pos     <= POS_W'(1);
          cur     <= lj ? {d_bit, {(WORD_W-1){1'b0}}} : '0;
        end else begin
          if (idx < POS_W'(WORD_W)) cur[bitsel] <= d_bit;
          if (pos != POS_MAX) pos <= pos + 1'b1;
        end
      end
    end

  assert_edge_clears_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> !bclk_lost);
  assert_loss_after_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_lost) |-> gap == GAP_MAX);
  assert_mute_when_lost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_lost && $past(bclk_lost)) |-> (left_out == '0 && right_out == '0));
  assert_no_strobe_when_lost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> !bclk_lost);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb);
  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_stb && !bclk_lost) |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic clk = 0, rst_n = 0;
  logic fmt_lj = 1, bclk = 0, fclk = 0, sdat = 0;
  logic [23:0] left_out, right_out;
  logic pair_stb, bclk_lost;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] q_l[$], q_r[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .bclk_in(bclk), .fclk_in(fclk),
    .sdat_in(sdat), .left_out(left_out), .right_out(right_out),
    .pair_stb(pair_stb), .bclk_lost(bclk_lost));

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R1: data flips while the bit clock is high, so only rising-edge capture works
  task automatic bit_cyc(input logic lvl, input logic b);
    bclk = 0; fclk = lvl; sdat = b;
    #40; bclk = 1;
    #10; sdat = ~b;
    #30;
  endtask

  task automatic send_half(input logic [23:0] w, input logic lvl, input int nb, input int extra);
    int dly = fmt_lj ? 0 : 1;
    for (int i = 0; i < dly + nb + extra; i++) begin
      int k = i - dly;
      bit_cyc(lvl, (k >= 0 && k < nb) ? w[23-k] : 1'b1);
    end
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                            input int nb, input int extra, input string tag);
    logic lvl = fmt_lj ? 1'b1 : 1'b0;
    logic [23:0] m = 24'hFFFFFF << (24 - nb);
    q_l.push_back(l & m); q_r.push_back(r & m); q_tag.push_back(tag);
    send_half(l, lvl, nb, extra);
    send_half(r, ~lvl, nb, extra);
  endtask

  task automatic preamble();
    for (int i = 0; i < 6; i++) bit_cyc(fmt_lj ? 1'b0 : 1'b1, 1'b1);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) bit_cyc(fmt_lj ? 1'b1 : 1'b0, 1'b0);
  endtask

  always @(negedge clk) if (pair_stb) begin
    if (q_l.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: unexpected pair %h/%h expected none", left_out, right_out);
    end else begin
      string t = q_tag.pop_front();
      check({t, " left"}, left_out, q_l.pop_front());
      check({t, " right"}, right_out, q_r.pop_front());
    end
  end

  task automatic stop_and_check(input logic [23:0] l_last, input logic [23:0] r_last);
    bclk = 0;
    repeat (50) @(negedge clk);
    check("R10 not lost before threshold", 24'(bclk_lost), 24'd0);
    check("R9 left holds", left_out, l_last);
    check("R9 right holds", right_out, r_last);
    repeat (30) @(negedge clk);
    check("R10 lost after quiet", 24'(bclk_lost), 24'd1);
    check("R11 left muted", left_out, 24'd0);
    check("R11 right muted", right_out, 24'd0);
    check("R11 no strobe", 24'(pair_stb), 24'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R12 strobe", 24'(pair_stb), 24'd0);
    check("R12 left", left_out, 24'd0);
    check("R12 right", right_out, 24'd0);
    check("R10 lost at reset", 24'(bclk_lost), 24'd1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    fmt_lj = 1;
    preamble();
    send_frame(24'hA5C3F1, 24'h5A3C0E, 24, 8, "R2 R4 R5 R7 lj");
    send_frame(24'h800001, 24'h7FFFFE, 24, 0, "R2 R6 lj tight");
    send_frame(24'h123456, 24'hFEDCBA, 16, 0, "R8 lj short");
    send_frame(24'h000001, 24'hFFFFFF, 24, 3, "R5 R1 lj");
    flush();
    repeat (10) @(negedge clk);
    stop_and_check(24'h000001, 24'hFFFFFF);

    fmt_lj = 0;
    repeat (10) @(negedge clk);
    preamble();
    send_frame(24'hC0FFEE, 24'h0BADF0, 24, 7, "R3 R4 R5 R7 i2s");
    send_frame(24'h800000, 24'h7FFFFF, 24, 0, "R3 R6 i2s tight");
    send_frame(24'h9ABCDE, 24'h13579B, 20, 0, "R8 i2s short");
    send_frame(24'h2468AC, 24'hE1D2C3, 24, 5, "R1 R11 i2s");
    flush();
    repeat (10) @(negedge clk);
    stop_and_check(24'h2468AC, 24'hE1D2C3);

    check("R9 all pairs delivered", 24'(q_l.size()), 24'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule